// File: doc/BRIEF.md
# Set/Clear Register Interrupt Controller

This block collects up to 32 interrupt inputs and presents them as two request lines. Software programs it through a small memory-mapped register file in which each control register is changed by writing ones to a set address or a clear address. A zero bit in the written word leaves the matching register bit untouched. This lets independent drivers change their own bits without a read-modify-write.

Each source has a 3-bit trigger code, with one bit held in each of three configuration registers. The code selects no detection, rising edge, falling edge, both edges, high level or low level. Edge events are held in two capture registers, one for rising and one for falling edges, and software acknowledges them by writing ones. A source that is pending and unmasked is steered by its routing bit to request 0 or to request 1. The pending word behind each request can be read back. The block also keeps a wake-enable register, a source-select register and a test register as stored state.

Top module: `setclr_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and both `req0` and `req1` are low.
- R2: Seven control registers each have a pair of addresses: trig0 (0x40 set, 0x44 clear), trig1 (0x48/0x4C), trig2 (0x50/0x54), srcsel (0x58/0x5C), route (0x60/0x64), wake (0x68/0x6C) and mask (0x70/0x74). A write to a set address ORs the one bits into the register, and a write to a clear address clears them. Reading a set address returns the register. Reading 0x44, 0x4C, 0x64, 0x6C or 0x74 returns zero.
- R3: The trigger code for source i is {trig2[i], trig1[i], trig0[i]}. Code 001 latches rising edges into the rising capture register, 010 latches falling edges into the falling capture register, and 011 latches both. An edge-mode source is pending while its enabled capture bit is set.
- R4: Code 101 makes a source pending while its synchronized input is 1, and code 110 while the input is 0. Level pending follows the input and is never latched.
- R5: The rising capture register is read at 0x78 and the falling capture register at 0x7C. Writing ones to either address clears those capture bits, and zero bits are left unchanged.
- R6: A source whose mask bit is 0 never drives `req0` or `req1`. Its edge captures are still recorded.
- R7: A pending, unmasked source drives request 0 when its route bit is 1 and request 1 when its route bit is 0. Reading 0x54 returns the request-0 pending word, and reading 0x5C returns the request-1 pending word. Each request output is the OR of its word.
- R8: Reads of unmapped offsets return zero, and writes to them change nothing.
- R9: Writing all ones to every clear address and to both capture addresses, and zero to the test register at 0x80, leaves both requests low with both capture registers empty.
- R10: Codes 000, 100 and 111 disable a source: it captures nothing and is never pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N | Asynchronous interrupt inputs |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data, combinational on bus_addr |
| req0 | output | 1 | Request line 0 |
| req1 | output | 1 | Request line 1 |

## Verification
The bench targets the cases where the modes differ. A falling edge under rising-only mode must leave no capture. A level source must drop its request as soon as its input returns, where a latched design would keep it high. A masked source must still record its edge while keeping both lines quiet, and a design that gated capture on the mask would lose that edge. Partial acknowledge and partial set/clear words catch a design that rewrites whole registers, and the status reads at the two shared clear addresses catch routing that is swapped between the request lines.

// File: rtl/setclr_irq_ctrl.sv
module setclr_irq_ctrl #(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_in,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  output logic          req0,
  output logic          req1
);
  localparam logic [AW-1:0] A_T0S = AW'('h40), A_T0C = AW'('h44);
  localparam logic [AW-1:0] A_T1S = AW'('h48), A_T1C = AW'('h4C);
  localparam logic [AW-1:0] A_T2S = AW'('h50), A_T2C = AW'('h54);
  localparam logic [AW-1:0] A_SSS = AW'('h58), A_SSC = AW'('h5C);
  localparam logic [AW-1:0] A_RTS = AW'('h60), A_RTC = AW'('h64);
  localparam logic [AW-1:0] A_WKS = AW'('h68), A_WKC = AW'('h6C);
  localparam logic [AW-1:0] A_MKS = AW'('h70), A_MKC = AW'('h74);
  localparam logic [AW-1:0] A_RIS = AW'('h78), A_FAL = AW'('h7C);
  localparam logic [AW-1:0] A_TST = AW'('h80);

  logic [N-1:0] trig0_q, trig1_q, trig2_q, srcsel_q, assign_q, wake_q, mask_q;
  logic [N-1:0] rise_q, fall_q, test_q;
  logic [N-1:0] sync1_q, sync2_q, prev_q;
  logic [N-1:0] rise_en, fall_en, lvl_hi, lvl_lo, pending, stat0, stat1;

  function automatic logic [N-1:0] setclr(logic [N-1:0] cur, logic s, logic c, logic [N-1:0] d);
    return (cur | (s ? d : '0)) & ~(c ? d : '0);
  endfunction

  function automatic logic hit(logic we, logic [AW-1:0] a, logic [AW-1:0] ref_a);
    return we && (a == ref_a);
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_src
    logic [2:0] code;
    assign code       = {trig2_q[i], trig1_q[i], trig0_q[i]};
    assign rise_en[i] = (code == 3'b001) || (code == 3'b011);
    assign fall_en[i] = (code == 3'b010) || (code == 3'b011);
    assign lvl_hi[i]  = (code == 3'b101);
    assign lvl_lo[i]  = (code == 3'b110);
  end

  assign pending = (rise_q & rise_en) | (fall_q & fall_en)
                 | (sync2_q & lvl_hi) | (~sync2_q & lvl_lo);
  assign stat0 = pending & mask_q & assign_q;
  assign stat1 = pending & mask_q & ~assign_q;
  assign req0  = |stat0;
  assign req1  = |stat1;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig0_q <= '0; trig1_q <= '0; trig2_q <= '0;
      srcsel_q <= '0; assign_q <= '0; wake_q <= '0; mask_q <= '0;
      rise_q <= '0; fall_q <= '0; test_q <= '0;
      sync1_q <= '0; sync2_q <= '0; prev_q <= '0;
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      trig0_q  <= setclr(trig0_q,  hit(bus_we, bus_addr, A_T0S), hit(bus_we, bus_addr, A_T0C), bus_wdata);
      trig1_q  <= setclr(trig1_q,  hit(bus_we, bus_addr, A_T1S), hit(bus_we, bus_addr, A_T1C), bus_wdata);
      trig2_q  <= setclr(trig2_q,  hit(bus_we, bus_addr, A_T2S), hit(bus_we, bus_addr, A_T2C), bus_wdata);
      srcsel_q <= setclr(srcsel_q, hit(bus_we, bus_addr, A_SSS), hit(bus_we, bus_addr, A_SSC), bus_wdata);
      assign_q <= setclr(assign_q, hit(bus_we, bus_addr, A_RTS), hit(bus_we, bus_addr, A_RTC), bus_wdata);
      wake_q   <= setclr(wake_q,   hit(bus_we, bus_addr, A_WKS), hit(bus_we, bus_addr, A_WKC), bus_wdata);
      mask_q   <= setclr(mask_q,   hit(bus_we, bus_addr, A_MKS), hit(bus_we, bus_addr, A_MKC), bus_wdata);
      rise_q <= (rise_q & ~(hit(bus_we, bus_addr, A_RIS) ? bus_wdata : '0))
              | (sync2_q & ~prev_q & rise_en);
      fall_q <= (fall_q & ~(hit(bus_we, bus_addr, A_FAL) ? bus_wdata : '0))
              | (~sync2_q & prev_q & fall_en);
      if (hit(bus_we, bus_addr, A_TST)) test_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_T0S:   bus_rdata = trig0_q;
      A_T1S:   bus_rdata = trig1_q;
      A_T2S:   bus_rdata = trig2_q;
      A_T2C:   bus_rdata = stat0;
      A_SSS:   bus_rdata = srcsel_q;
      A_SSC:   bus_rdata = stat1;
      A_RTS:   bus_rdata = assign_q;
      A_WKS:   bus_rdata = wake_q;
      A_MKS:   bus_rdata = mask_q;
      A_RIS:   bus_rdata = rise_q;
      A_FAL:   bus_rdata = fall_q;
      A_TST:   bus_rdata = test_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/setclr_irq_ctrl_chk.sv
module setclr_irq_ctrl_chk #(
  parameter int N  = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  bus_rdata,
  input logic          req0,
  input logic          req1,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  assign_q
);
  // R6
  mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |-> (!req0 && !req1));
  // R7
  req0_route_chk: assert property (@(posedge clk) disable iff (rst)
    req0 |-> ((mask_q & assign_q) != '0));
  // R7
  req1_route_chk: assert property (@(posedge clk) disable iff (rst)
    req1 |-> ((mask_q & ~assign_q) != '0));
  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'('h70)) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));
  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'('h74)) |=> ((mask_q & $past(bus_wdata)) == '0));
  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr > AW'('h80)) |-> (bus_rdata == '0));
endmodule

bind setclr_irq_ctrl setclr_irq_ctrl_chk #(.N(N), .AW(AW)) u_chk (.*);

// File: tb/tb_setclr_irq_ctrl.sv
`timescale 1ns/1ps
module tb_setclr_irq_ctrl;
  localparam int N = 32;
  localparam int AW = 8;
  localparam int NV = 12;
  // {code[2:0], mask, route, lvl_before, lvl_after, exp_req0, exp_req1, exp_rise, exp_fall}
  localparam logic [10:0] VEC [NV] = '{
    11'b001_11_01_1010, 11'b001_11_10_0000, 11'b010_10_10_0101, 11'b011_11_10_1001,
    11'b011_10_01_0110, 11'b101_11_01_1000, 11'b101_11_10_0000, 11'b110_10_10_0100,
    11'b001_01_01_0010, 11'b000_11_01_0000, 11'b100_11_01_0000, 11'b111_10_10_0000};

  logic clk = 0, rst = 1, bus_we = 0;
  logic [N-1:0] irq_in = '0, bus_wdata = '0, bus_rdata;
  logic [AW-1:0] bus_addr = '0;
  logic req0, req1;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [N-1:0] rv;

  setclr_irq_ctrl #(.N(N), .AW(AW)) dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_we = 0; bus_addr = '0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic quiet_all();
    foreach (VEC[k]) begin end
    wr(8'h44, '1); wr(8'h4C, '1); wr(8'h54, '1); wr(8'h5C, '1); wr(8'h64, '1);
    wr(8'h6C, '1); wr(8'h74, '1); wr(8'h78, '1); wr(8'h7C, '1); wr(8'h80, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    @(negedge clk);
    chk("R1 req0", {31'b0, req0}, 0);
    chk("R1 req1", {31'b0, req1}, 0);
    rd(8'h40, rv); chk("R1 trig0", rv, 0);
    rd(8'h70, rv); chk("R1 mask", rv, 0);
    rd(8'h78, rv); chk("R1 rise", rv, 0);

    // Vector walk: R3 R4 R6 R7 R10
    for (int i = 0; i < NV; i++) begin
      int s;
      logic [10:0] v;
      s = (i * 7 + 1) % N;
      v = VEC[i];
      quiet_all();
      irq_in = '0; irq_in[s] = v[5];
      repeat (4) @(posedge clk);
      if (v[8])  wr(8'h40, 1 << s);
      if (v[9])  wr(8'h48, 1 << s);
      if (v[10]) wr(8'h50, 1 << s);
      if (v[7])  wr(8'h70, 1 << s);
      if (v[6])  wr(8'h60, 1 << s);
      repeat (3) @(posedge clk);
      wr(8'h78, '1); wr(8'h7C, '1);
      @(negedge clk); irq_in[s] = v[4];
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk($sformatf("R3/R4/R6/R7/R10 vec %0d req0", i), {31'b0, req0}, {31'b0, v[3]});
      chk($sformatf("R3/R4/R6/R7/R10 vec %0d req1", i), {31'b0, req1}, {31'b0, v[2]});
      rd(8'h78, rv); chk($sformatf("R3/R6/R10 vec %0d rise", i), rv[s], v[1]);
      rd(8'h7C, rv); chk($sformatf("R3/R6/R10 vec %0d fall", i), rv[s], v[0]);
    end

    // R2 set/clear semantics
    quiet_all(); irq_in = '0;
    wr(8'h70, 32'h0000_00F0); wr(8'h70, 32'h0000_000F);
    rd(8'h70, rv); chk("R2 mask set", rv, 32'h0000_00FF);
    wr(8'h74, 32'h0000_003C);
    rd(8'h70, rv); chk("R2 mask clear", rv, 32'h0000_00C3);
    rd(8'h74, rv); chk("R2 clear addr read", rv, 0);
    wr(8'h68, 32'hA000_0001); wr(8'h6C, 32'h2000_0000);
    rd(8'h68, rv); chk("R2 wake", rv, 32'h8000_0001);

    // R5 selective acknowledge, R7 status words
    quiet_all();
    wr(8'h40, 32'h0000_000C);
    repeat (3) @(posedge clk);
    @(negedge clk); irq_in = 32'h0000_000C;
    repeat (5) @(posedge clk);
    rd(8'h78, rv); chk("R5 both captured", rv, 32'h0000_000C);
    wr(8'h70, 32'h0000_000C); wr(8'h60, 32'h0000_0004);
    rd(8'h54, rv); chk("R7 status0", rv, 32'h0000_0004);
    rd(8'h5C, rv); chk("R7 status1", rv, 32'h0000_0008);
    wr(8'h78, 32'h0000_0004);
    rd(8'h78, rv); chk("R5 partial ack", rv, 32'h0000_0008);
    @(negedge clk);
    chk("R5 req0 after ack", {31'b0, req0}, 0);
    chk("R5 req1 kept", {31'b0, req1}, 1);

    // R8 unmapped offsets
    wr(8'h90, '1); wr(8'h04, '1);
    rd(8'h90, rv); chk("R8 read 0x90", rv, 0);
    rd(8'h04, rv); chk("R8 read 0x04", rv, 0);
    rd(8'h70, rv); chk("R8 mask untouched", rv, 32'h0000_000C);
    @(negedge clk); chk("R8 req1 untouched", {31'b0, req1}, 1);

    // R9 quiet sequence with inputs still high
    wr(8'h50, 32'h0000_0010); wr(8'h40, 32'h0000_0010); wr(8'h70, 32'h0000_0010);
    @(negedge clk); irq_in[4] = 1'b1;
    repeat (4) @(posedge clk);
    quiet_all();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 req0", {31'b0, req0}, 0);
    chk("R9 req1", {31'b0, req1}, 0);
    rd(8'h78, rv); chk("R9 rise empty", rv, 0);
    rd(8'h7C, rv); chk("R9 fall empty", rv, 0);
    rd(8'h80, rv); chk("R9 test reg", rv, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule